// File: doc/BRIEF.md
# Translucent Text Overlay Generator

This block draws a grid of text characters over the primary video. It runs at the pixel clock and is given the current pixel position inside the active picture. It reads the character code for that screen cell from a small dual-port character memory. A computed glyph table turns the code into pixel bits. The block then mixes the result into the primary colour stream.

Behind the text, the primary picture shows at reduced brightness. Each primary colour component is shifted down, so the overlay reads as a translucent panel. A host processor fills the character memory through a simple address/data/write-enable port. Sync timing and the primary video path are outside the block.

When the overlay enable is low, or the pixel lies outside the text area, the primary colour passes through unchanged. It takes the same pipeline delay as overlay pixels. That keeps the output aligned whatever the enable does.

Top module: `osd_overlay`

## Requirements
- R1: While reset is asserted, and until the first pixel sampled after reset reaches the output, all three output colour components are zero.
- R2: Every output is due exactly 3 clocks after its pixel inputs are sampled. With the overlay enable low, the output equals the primary colour sampled 3 clocks earlier.
- R3: A pixel with X >= 192 or Y >= 64 lies outside the text area. Such a pixel passes the primary colour through unchanged, even with the overlay enabled.
- R4: Cells are 6 pixels wide and 8 tall. The pixel (X,Y) belongs to character column X/6 and text line Y/8. Its code is read at character-memory address line*32 + column, where 32 is the number of columns per line and the grid is 8 lines deep.
- R5: Code bits [6:0] minus 0x20 give the glyph index g. Row r (0..6) of glyph g is the 5-bit value ((g*11 + r*7 + 3) mod 32) XOR (g >> 1). Cell column c (0..4) shows bit 4-c of that row, so bit 4 is the leftmost pixel.
- R6: A foreground pixel is full-scale white (0xFF on every component). A background pixel shows each primary component shifted right by one bit. Each pixel is one or the other on all three components.
- R7: Column 5 and row 7 of every cell are padding and show background.
- R8: When code bit 7 is set, every pixel of the cell swaps foreground and background, padding included.
- R9: A code whose bits [6:0] fall outside 0x20..0x5F renders as a blank cell. The cell is all background, or all foreground if bit 7 is set.
- R10: A character-memory write changes what pixel lookups see from the next clock on. A pixel sampled in the same clock as a write to its cell still uses the old code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Character-memory write enable |
| cpu_addr | input | 8 | Character-memory write address (line*32 + column) |
| cpu_data | input | 8 | Character code to write; bit 7 inverts the cell |
| pix_x | input | 8 | Horizontal pixel position |
| pix_y | input | 7 | Vertical pixel position |
| ovl_en | input | 1 | Overlay active for this pixel |
| prim_r | input | 8 | Primary red component |
| prim_g | input | 8 | Primary green component |
| prim_b | input | 8 | Primary blue component |
| ovl_r | output | 8 | Mixed red component |
| ovl_g | output | 8 | Mixed green component |
| ovl_b | output | 8 | Mixed blue component |

## Verification
Each pixel result is due three clocks after its inputs, whether it is overlaid, padding or passed through. The bench drives one pixel per falling edge and keeps a three-deep queue of predicted colours, compared three falling edges later. Character-memory writes enter the bench's shadow copy only after the prediction for the same cycle is made. This matches the rule that a lookup in the write cycle still sees the old code. A dedicated sequence checks the cycle of the write and the cycle after it.

// File: rtl/osd_pkg.sv
package osd_pkg;

   localparam logic [6:0] CODE_FIRST = 7'h20;
   localparam logic [6:0] CODE_LAST  = 7'h5F;
   localparam int         FONT_W     = 5;
   localparam int         FONT_H     = 7;

   // Built-in computed font: one 5-bit row per (glyph index, row)
   function automatic logic [FONT_W-1:0] glyph_row(input logic [5:0] g, input logic [2:0] r);
      logic [9:0] t;
      t = 10'(g) * 10'd11 + 10'(r) * 10'd7 + 10'd3;
      return t[4:0] ^ g[5:1];
   endfunction

endpackage

// File: rtl/osd_vram.sv
module osd_vram #(
   parameter int DW    = 8,
   parameter int DEPTH = 256,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   // Read-before-write: a read in the write cycle returns the old word
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/osd_glyph_rom.sv
module osd_glyph_rom #(
   parameter int GLYPH_W = 5,
   parameter int GLYPH_H = 7,
   parameter int SYW     = 3
) (
   input  logic               clk,
   input  logic [7:0]         code,
   input  logic [SYW-1:0]     row,
   output logic [GLYPH_W-1:0] bits,
   output logic               known
);

   logic [6:0] idx7;
   logic       in_set;
   logic       row_ok;

   always_comb begin
      idx7   = code[6:0] - osd_pkg::CODE_FIRST;
      in_set = (code[6:0] >= osd_pkg::CODE_FIRST) && (code[6:0] <= osd_pkg::CODE_LAST);
      row_ok = int'(row) < GLYPH_H;
   end

   always_ff @(posedge clk) begin
      bits  <= row_ok ? osd_pkg::glyph_row(idx7[5:0], 3'(row)) : '0;
      known <= in_set;
   end

endmodule

// File: rtl/osd_mixer.sv
module osd_mixer #(
   parameter int CW          = 8,
   parameter int SHADE_SHIFT = 1,
   parameter bit TRANSLUCENT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act,
   input  logic            fg,
   input  logic [3*CW-1:0] prim,
   output logic [3*CW-1:0] mixed
);

   localparam int NCH = 3;

   logic [CW-1:0] nxt [NCH];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [CW-1:0] comp;
      logic [CW-1:0] base;
      assign comp = prim[ch*CW +: CW];
      if (TRANSLUCENT) begin : g_shade
         assign base = comp >> SHADE_SHIFT;
      end else begin : g_opaque
         assign base = '0;
      end
      assign nxt[ch] = !act ? comp : (fg ? {CW{1'b1}} : base);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mixed <= '0;
      else        mixed <= {nxt[2], nxt[1], nxt[0]};
   end

endmodule

// File: rtl/osd_overlay.sv
module osd_overlay #(
   parameter int CW          = 8,
   parameter int COLS        = 32,
   parameter int ROWS        = 8,
   parameter int CELL_W      = 6,
   parameter int CELL_H      = 8,
   parameter int GLYPH_W     = 5,
   parameter int GLYPH_H     = 7,
   parameter int XW          = 8,
   parameter int YW          = 7,
   parameter int SHADE_SHIFT = 1,
   parameter bit TRANSLUCENT = 1'b1,
   localparam int AW         = $clog2(COLS * ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [7:0]    cpu_data,
   input  logic [XW-1:0] pix_x,
   input  logic [YW-1:0] pix_y,
   input  logic          ovl_en,
   input  logic [CW-1:0] prim_r,
   input  logic [CW-1:0] prim_g,
   input  logic [CW-1:0] prim_b,
   output logic [CW-1:0] ovl_r,
   output logic [CW-1:0] ovl_g,
   output logic [CW-1:0] ovl_b
);

   localparam int DEPTH = COLS * ROWS;
   localparam int TXT_W = COLS * CELL_W;
   localparam int TXT_H = ROWS * CELL_H;
   localparam int SXW   = $clog2(CELL_W);
   localparam int SYW   = $clog2(CELL_H);

   if (CELL_W <= GLYPH_W || CELL_H <= GLYPH_H) begin : g_bad_cell
      $error("cell must be larger than glyph to leave padding");
   end
   if (GLYPH_W != osd_pkg::FONT_W || GLYPH_H > osd_pkg::FONT_H || CELL_H > 8) begin : g_bad_font
      $error("built-in font supports 5-wide glyphs up to 7 rows");
   end
   if (XW < $clog2(TXT_W) || YW < $clog2(TXT_H)) begin : g_bad_coord
      $error("coordinate ports too narrow for text area");
   end
   if (SHADE_SHIFT < 1 || SHADE_SHIFT >= CW) begin : g_bad_shade
      $error("shade shift must be between 1 and CW-1");
   end

   // Stage 0: cell decode and character-memory address
   logic          inside0;
   logic [SXW-1:0] sx0;
   logic [SYW-1:0] sy0;
   logic [AW-1:0] rd_addr0;

   always_comb begin
      inside0  = (int'(pix_x) < TXT_W) && (int'(pix_y) < TXT_H);
      sx0      = SXW'(int'(pix_x) % CELL_W);
      sy0      = SYW'(int'(pix_y) % CELL_H);
      rd_addr0 = AW'((int'(pix_y) / CELL_H) * COLS + int'(pix_x) / CELL_W);
   end

   logic [7:0] code1;

   osd_vram #(.DW(8), .DEPTH(DEPTH), .AW(AW)) u_vram (
      .clk   (clk),
      .we    (cpu_we),
      .waddr (cpu_addr),
      .wdata (cpu_data),
      .raddr (rd_addr0),
      .rdata (code1)
   );

   // Stage 1: code available
   logic            act1;
   logic [SXW-1:0]  sx1;
   logic [SYW-1:0]  sy1;
   logic [3*CW-1:0] prim1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act1  <= 1'b0;
         sx1   <= '0;
         sy1   <= '0;
         prim1 <= '0;
      end else begin
         act1  <= ovl_en & inside0;
         sx1   <= sx0;
         sy1   <= sy0;
         prim1 <= {prim_r, prim_g, prim_b};
      end
   end

   logic [GLYPH_W-1:0] bits2;
   logic               known2;

   osd_glyph_rom #(.GLYPH_W(GLYPH_W), .GLYPH_H(GLYPH_H), .SYW(SYW)) u_rom (
      .clk   (clk),
      .code  (code1),
      .row   (sy1),
      .bits  (bits2),
      .known (known2)
   );

   // Stage 2: glyph row available
   logic            act2;
   logic            inv2;
   logic [SXW-1:0]  sx2;
   logic [SYW-1:0]  sy2;
   logic [3*CW-1:0] prim2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act2  <= 1'b0;
         inv2  <= 1'b0;
         sx2   <= '0;
         sy2   <= '0;
         prim2 <= '0;
      end else begin
         act2  <= act1;
         inv2  <= code1[7];
         sx2   <= sx1;
         sy2   <= sy1;
         prim2 <= prim1;
      end
   end

   logic [GLYPH_W-1:0] aligned2;
   logic               hit2;
   logic               fg2;

   always_comb begin
      aligned2 = bits2 << sx2;
      hit2     = known2 && (int'(sx2) < GLYPH_W) && (int'(sy2) < GLYPH_H)
                 && aligned2[GLYPH_W-1];
      fg2      = hit2 ^ inv2;
   end

   logic [3*CW-1:0] mixed3;

   osd_mixer #(.CW(CW), .SHADE_SHIFT(SHADE_SHIFT), .TRANSLUCENT(TRANSLUCENT)) u_mix (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act2),
      .fg    (fg2),
      .prim  (prim2),
      .mixed (mixed3)
   );

   assign ovl_r = mixed3[3*CW-1:2*CW];
   assign ovl_g = mixed3[2*CW-1:CW];
   assign ovl_b = mixed3[CW-1:0];

endmodule

// File: rtl/osd_overlay_chk.sv
module osd_overlay_chk #(
   parameter int CW          = 8,
   parameter int TXT_W       = 192,
   parameter int TXT_H       = 64,
   parameter int XW          = 8,
   parameter int YW          = 7,
   parameter int SHADE_SHIFT = 1,
   parameter bit TRANSLUCENT = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [XW-1:0] pix_x,
   input logic [YW-1:0] pix_y,
   input logic          ovl_en,
   input logic [CW-1:0] prim_r,
   input logic [CW-1:0] prim_g,
   input logic [CW-1:0] prim_b,
   input logic [CW-1:0] ovl_r,
   input logic [CW-1:0] ovl_g,
   input logic [CW-1:0] ovl_b
);

   logic [1:0] warm;
   logic       outside;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   assign outside = (int'(pix_x) >= TXT_W) || (int'(pix_y) >= TXT_H);

   assert_pass_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && !$past(ovl_en, 3)) |->
      (ovl_r == $past(prim_r, 3) && ovl_g == $past(prim_g, 3) && ovl_b == $past(prim_b, 3)));

   assert_pass_outside_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && $past(outside, 3)) |->
      (ovl_r == $past(prim_r, 3) && ovl_g == $past(prim_g, 3) && ovl_b == $past(prim_b, 3)));

   assert_fg_or_bg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && $past(ovl_en, 3) && !$past(outside, 3)) |->
      ((ovl_r == {CW{1'b1}} || ovl_r == (TRANSLUCENT ? ($past(prim_r, 3) >> SHADE_SHIFT) : '0)) &&
       (ovl_g == {CW{1'b1}} || ovl_g == (TRANSLUCENT ? ($past(prim_g, 3) >> SHADE_SHIFT) : '0)) &&
       (ovl_b == {CW{1'b1}} || ovl_b == (TRANSLUCENT ? ($past(prim_b, 3) >> SHADE_SHIFT) : '0))));

   assert_pixel_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd3 && $past(ovl_en, 3) && !$past(outside, 3)) |->
      ((ovl_r == {CW{1'b1}} && ovl_g == {CW{1'b1}} && ovl_b == {CW{1'b1}}) ||
       (ovl_r != {CW{1'b1}} && ovl_g != {CW{1'b1}} && ovl_b != {CW{1'b1}})));

endmodule

bind osd_overlay osd_overlay_chk #(
   .CW(CW), .TXT_W(COLS * CELL_W), .TXT_H(ROWS * CELL_H), .XW(XW), .YW(YW),
   .SHADE_SHIFT(SHADE_SHIFT), .TRANSLUCENT(TRANSLUCENT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .ovl_en(ovl_en),
   .prim_r(prim_r), .prim_g(prim_g), .prim_b(prim_b),
   .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b)
);

// File: tb/tb_osd_overlay.sv
module tb_osd_overlay;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cpu_we;
   logic [7:0] cpu_addr;
   logic [7:0] cpu_data;
   logic [7:0] pix_x;
   logic [6:0] pix_y;
   logic       ovl_en;
   logic [7:0] prim_r, prim_g, prim_b;
   logic [7:0] ovl_r, ovl_g, ovl_b;

   always #4 clk = ~clk;

   osd_overlay dut (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .pix_x(pix_x), .pix_y(pix_y), .ovl_en(ovl_en),
      .prim_r(prim_r), .prim_g(prim_g), .prim_b(prim_b),
      .ovl_r(ovl_r), .ovl_g(ovl_g), .ovl_b(ovl_b)
   );

   int          checks = 0;
   int          errors = 0;
   logic [7:0]  shadow [256];
   logic [23:0] exp_q [3];
   string       tag_q [3];
   int          filled = 0;

   function automatic logic [4:0] font_row(int g, int r);
      int t;
      t = g * 11 + r * 7 + 3;
      return 5'(t) ^ 5'(g >> 1);
   endfunction

   task automatic predict(input int x, input int y, input logic en,
                          input logic [23:0] prim, output logic [23:0] e, output string tg);
      int col, ln, sx, sy, c;
      logic [7:0] code;
      logic inv, valid, bitv, on;
      logic [4:0] rowv;
      if (!en) begin
         e = prim; tg = "R2"; return;
      end
      if (x >= 192 || y >= 64) begin
         e = prim; tg = "R3"; return;
      end
      col = x / 6; ln = y / 8; sx = x % 6; sy = y % 8;
      code  = shadow[ln * 32 + col];
      inv   = code[7];
      c     = int'(code[6:0]);
      valid = (c >= 32) && (c <= 95);
      bitv  = 1'b0;
      if (valid && sx < 5 && sy < 7) begin
         rowv = font_row(c - 32, sy);
         bitv = rowv[4 - sx];
      end
      on = bitv ^ inv;
      e  = on ? 24'hFFFFFF : {prim[23:16] >> 1, prim[15:8] >> 1, prim[7:0] >> 1};
      if (!valid)                tg = inv ? "R8" : "R9";
      else if (sx == 5 || sy == 7) tg = inv ? "R8" : "R7";
      else if (inv)              tg = "R8";
      else                       tg = on ? "R5" : "R6";
   endtask

   task automatic step(input int x, input int y, input logic en, input logic [23:0] prim,
                       input logic we, input logic [7:0] a, input logic [7:0] d, input string ov);
      logic [23:0] e;
      string tg;
      @(negedge clk);
      if (filled >= 3) begin
         checks++;
         if ({ovl_r, ovl_g, ovl_b} !== exp_q[2]) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag_q[2], {ovl_r, ovl_g, ovl_b}, exp_q[2]);
         end
      end else begin
         checks++;
         if ({ovl_r, ovl_g, ovl_b} !== 24'h0) begin
            errors++;
            $display("FAIL R1 got %h expected 000000 before first pixel", {ovl_r, ovl_g, ovl_b});
         end
      end
      exp_q[2] = exp_q[1]; tag_q[2] = tag_q[1];
      exp_q[1] = exp_q[0]; tag_q[1] = tag_q[0];
      predict(x, y, en, prim, e, tg);
      exp_q[0] = e;
      tag_q[0] = (ov != "") ? ov : tg;
      pix_x  = 8'(x);
      pix_y  = 7'(y);
      ovl_en = en;
      {prim_r, prim_g, prim_b} = prim;
      cpu_we   = we;
      cpu_addr = a;
      cpu_data = d;
      if (we) shadow[a] = d;
      filled++;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL R2 got hang expected completion (watchdog)");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_data = '0;
      pix_x = '0; pix_y = '0; ovl_en = 1'b0; prim_r = 8'h11; prim_g = 8'h22; prim_b = 8'h33;
      repeat (3) @(negedge clk);
      checks++;
      if ({ovl_r, ovl_g, ovl_b} !== 24'h0) begin
         errors++;
         $display("FAIL R1 got %h expected 000000 in reset", {ovl_r, ovl_g, ovl_b});
      end
      prim_r = 8'h0; prim_g = 8'h0; prim_b = 8'h0;
      rst_n = 1'b1;

      // Fill the character memory while the overlay is off (R2 passthrough)
      for (int a = 0; a < 256; a++)
         step($urandom_range(0, 255), $urandom_range(0, 100), 1'b0, 24'($urandom),
              1'b1, 8'(a), 8'($urandom), "");

      // Directed corner codes in line 0
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd0, 8'h41, "");
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd1, 8'hC1, "");
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd2, 8'h10, "");
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd3, 8'h7F, "");
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd4, 8'h5F, "");
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd5, 8'h60, "");
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd6, 8'h20, "");
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd7, 8'hE0, "");
      for (int y = 0; y < 8; y++)
         for (int x = 0; x < 48; x++)
            step(x, y, 1'b1, 24'hA53CFF, 1'b0, 8'd0, 8'd0, "");

      // Address mapping at the far corner and the edges of the area (R4, R3)
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd255, 8'h23, "");
      for (int y = 56; y < 64; y++)
         for (int x = 186; x < 192; x++)
            step(x, y, 1'b1, 24'h808080, 1'b0, 8'd0, 8'd0, "R4");
      step(6, 8, 1'b1, 24'h123456, 1'b0, 8'd0, 8'd0, "R4");
      step(192, 10, 1'b1, 24'h123456, 1'b0, 8'd0, 8'd0, "");
      step(10, 64, 1'b1, 24'h654321, 1'b0, 8'd0, 8'd0, "");
      step(255, 127, 1'b1, 24'hFEDCBA, 1'b0, 8'd0, 8'd0, "");

      // Write in the same cycle as a lookup of that cell, then the next cycle (R10)
      step(0, 0, 1'b0, 24'h0, 1'b1, 8'd40, 8'h20, "");
      step(49, 9, 1'b1, 24'h4080C0, 1'b1, 8'd40, 8'hA0, "R10");
      step(49, 9, 1'b1, 24'h4080C0, 1'b0, 8'd0, 8'd0, "R10");
      step(49, 9, 1'b1, 24'h4080C0, 1'b1, 8'd40, 8'h5F, "R10");
      step(49, 9, 1'b1, 24'h4080C0, 1'b0, 8'd0, 8'd0, "R10");

      // Constrained random stream
      for (int i = 0; i < 6000; i++) begin
         logic wr;
         wr = ($urandom_range(0, 15) == 0);
         step($urandom_range(0, 230), $urandom_range(0, 70), ($urandom_range(0, 7) != 0),
              24'($urandom), wr, 8'($urandom), 8'($urandom), "");
      end

      // Drain the pipeline
      for (int i = 0; i < 4; i++) step(0, 0, 1'b0, 24'h0, 1'b0, 8'd0, 8'd0, "");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule